// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 8-bit operands over eight clock cycles. It uses one adder and a small controller instead of an array of adders. The two operands are written into internal registers by separate load strobes while the block is idle.

A start pulse clears the accumulator and launches eight identical steps. In each step the accumulator adds either the current multiplicand or zero, chosen by the multiplier's least significant bit. The same step shifts the multiplier right by one bit and the multiplicand left by one bit. A single combined strobe drives all of this in every step.

The controller state is a marker bit plus a step counter. The marker bit drives the busy output. When the count wraps, the controller drops back to idle. The 16-bit product then stays in the accumulator until the next start.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, busy_o is 0 and product_o is 0.
- R2: While idle and start_i is low, busy_o stays 0.
- R3: A start_i sampled high while idle makes busy_o go high on the next clock edge, and product_o reads 0 at that edge.
- R4: Eight clock edges after busy_o rises, busy_o is 0 again and product_o equals the unsigned 16-bit product of the loaded multiplicand and multiplier.
- R5: After k steps (k = 1 to 8), product_o equals the multiplicand times the low k bits of the multiplier. Each step adds the shifted multiplicand when the multiplier LSB is 1, and adds zero when it is 0.
- R6: While busy_o is 1, pulses on mplr_ld_i and mcnd_ld_i have no effect on the product being formed.
- R7: While idle, product_o holds its value, even when the load strobes change the operand registers.
- R8: While busy_o is 1, start_i is ignored. The run neither restarts nor lengthens.
- R9: Each run shifts out the operand registers. A second start with no reload therefore yields a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mplr_ld_i | input | 1 | Writes mplr_i into the multiplier register when idle |
| mplr_i | input | 8 | Multiplier operand |
| mcnd_ld_i | input | 1 | Writes mcnd_i into the multiplicand register when idle |
| mcnd_i | input | 8 | Multiplicand operand |
| start_i | input | 1 | Launches a multiply when idle |
| busy_o | output | 1 | High during the eight step cycles |
| product_o | output | 16 | Accumulator contents |

## Verification
The clear from a start is visible one edge after start is sampled, together with the rise of busy_o. Each step's partial sum is visible one edge later, and the full product is visible on the eighth edge after busy_o rises, in the same cycle busy_o falls. The bench drives inputs and samples outputs at falling edges. It compares product_o after every single edge of a run against the expected partial product, so a result that arrives one cycle early or late is reported. During runs it drives stray loads and starts, and in idle it toggles the load strobes while checking that the product holds.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef struct packed {
    logic clr;    // zero accumulator
    logic ld_sh;  // add selected value, shift both operands
  } mul_ctrl_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int OP_W = 8,
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                busy_o,
  output mul_pkg::mul_ctrl_t  ctrl_o
);
  // state = {run marker, step count}; idle is all zeros
  logic             run_q;
  logic [CNT_W-1:0] step_q;
  logic             last_step;

  assign last_step = (step_q == CNT_W'(OP_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      step_q <= '0;
    end else if (run_q) begin
      step_q <= last_step ? '0 : step_q + 1'b1;
      run_q  <= !last_step;
    end else if (start_i) begin
      run_q  <= 1'b1;
      step_q <= '0;
    end
  end

  assign busy_o       = run_q;
  assign ctrl_o.clr   = !run_q && start_i;
  assign ctrl_o.ld_sh = run_q;
endmodule

// File: rtl/mul_oprnd.sv
module mul_oprnd #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2*OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              shift_i,
  input  logic              mplr_ld_i,
  input  logic [OP_W-1:0]   mplr_i,
  input  logic              mcnd_ld_i,
  input  logic [OP_W-1:0]   mcnd_i,
  output logic              lsb_o,
  output logic [PROD_W-1:0] mcnd_o
);
  logic [OP_W-1:0]   mplr_q;
  logic [PROD_W-1:0] mcnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mplr_q <= '0;
    end else if (shift_i) begin
      mplr_q <= mplr_q >> 1;
    end else if (!busy_i && mplr_ld_i) begin
      mplr_q <= mplr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcnd_q <= '0;
    end else if (shift_i) begin
      mcnd_q <= mcnd_q << 1;
    end else if (!busy_i && mcnd_ld_i) begin
      mcnd_q <= {{OP_W{1'b0}}, mcnd_i};
    end
  end

  assign lsb_o  = mplr_q[0];
  assign mcnd_o = mcnd_q;
endmodule

// File: rtl/mul_acc.sv
module mul_acc #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2*OP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mul_pkg::mul_ctrl_t ctrl_i,
  input  logic               lsb_i,
  input  logic [PROD_W-1:0]  mcnd_i,
  output logic [PROD_W-1:0]  acc_o
);
  logic [PROD_W-1:0] sel;
  logic [PROD_W-1:0] acc_q;

  // pass-or-zero keeps a single step strobe for both digit values
  assign sel = lsb_i ? mcnd_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (ctrl_i.clr) begin
      acc_q <= '0;
    end else if (ctrl_i.ld_sh) begin
      acc_q <= acc_q + sel;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2*OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mplr_ld_i,
  input  logic [OP_W-1:0]   mplr_i,
  input  logic              mcnd_ld_i,
  input  logic [OP_W-1:0]   mcnd_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic [PROD_W-1:0] product_o
);
  mul_pkg::mul_ctrl_t ctrl;
  logic               lsb;
  logic [PROD_W-1:0]  mcnd_sh;

  mul_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .ctrl_o  (ctrl)
  );

  mul_oprnd #(.OP_W(OP_W)) u_oprnd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_o),
    .shift_i   (ctrl.ld_sh),
    .mplr_ld_i (mplr_ld_i),
    .mplr_i    (mplr_i),
    .mcnd_ld_i (mcnd_ld_i),
    .mcnd_i    (mcnd_i),
    .lsb_o     (lsb),
    .mcnd_o    (mcnd_sh)
  );

  mul_acc #(.OP_W(OP_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .lsb_i  (lsb),
    .mcnd_i (mcnd_sh),
    .acc_o  (product_o)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2*OP_W,
  localparam int LEN_W = $clog2(OP_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [PROD_W-1:0] product_o
);
  logic [LEN_W-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  a_r3_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && product_o == '0));

  a_r4_run_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_len == LEN_W'(OP_W-1)) |=> !busy_o);

  a_r8_run_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_len < LEN_W'(OP_W-1)) |=> busy_o);

  a_r5_acc_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> product_o >= $past(product_o));

  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind shift_add_mul mul_chk #(.OP_W(OP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .product_o (product_o)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mplr_ld = 1'b0, mcnd_ld = 1'b0, start = 1'b0;
  logic [7:0]  mplr = '0, mcnd = '0;
  logic        busy;
  logic [15:0] prod;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  shift_add_mul u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mplr_ld_i(mplr_ld), .mplr_i(mplr),
    .mcnd_ld_i(mcnd_ld), .mcnd_i(mcnd), .start_i(start),
    .busy_o(busy), .product_o(prod)
  );

  function automatic logic [15:0] exp_part(logic [7:0] a, logic [7:0] b, int k);
    logic [15:0] m;
    m = (k >= 8) ? 16'h00ff : ((16'd1 << k) - 16'd1);
    return 16'(a) * (16'(b) & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // a = multiplicand, b = multiplier; noisy drives stray loads/starts while busy
  task automatic run_mul(logic [7:0] a, logic [7:0] b, bit reload, bit noisy);
    @(negedge clk);
    if (reload) begin
      mcnd = a; mplr = b; mcnd_ld = 1'b1; mplr_ld = 1'b1;
      @(negedge clk);
      mcnd_ld = 1'b0; mplr_ld = 1'b0;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy", 32'(busy), 32'd1);
    chk("R3 clear", 32'(prod), 32'd0);
    for (int k = 1; k <= 8; k++) begin
      if (noisy) begin
        mcnd = 8'($urandom); mplr = 8'($urandom);
        mcnd_ld = 1'b1; mplr_ld = 1'b1; start = 1'b1;
      end
      @(negedge clk);
      mcnd_ld = 1'b0; mplr_ld = 1'b0; start = 1'b0;
      if (k < 8) begin
        chk(noisy ? "R6 partial" : "R5 partial", 32'(prod), 32'(exp_part(a, b, k)));
        chk("R8 busy", 32'(busy), 32'd1);
      end else begin
        chk("R4 product", 32'(prod), 32'(16'(a) * 16'(b)));
        chk("R4 done", 32'(busy), 32'd0);
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    #12;
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 product", 32'(prod), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 idle", 32'(busy), 32'd0);

    run_mul(8'd4, 8'd3, 1'b1, 1'b0);
    run_mul(8'd0, 8'd0, 1'b1, 1'b0);
    run_mul(8'hff, 8'hff, 1'b1, 1'b0);
    run_mul(8'd1, 8'hff, 1'b1, 1'b0);
    run_mul(8'hff, 8'd1, 1'b1, 1'b0);
    run_mul(8'h80, 8'h80, 1'b1, 1'b1);
    // R9: restart with shifted-out operands
    run_mul(8'd0, 8'd0, 1'b0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      run_mul(a, b, 1'b1, i[0]);
      held = prod;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        mcnd = 8'($urandom); mplr = 8'($urandom);
        mcnd_ld = 1'b1; mplr_ld = 1'b1;
        @(negedge clk);
        mcnd_ld = 1'b0; mplr_ld = 1'b0;
        chk("R7 hold", 32'(prod), 32'(held));
        chk("R2 idle", 32'(busy), 32'd0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule